// File: doc/BRIEF.md
# Double-to-Single Store Narrowing Converter

This block turns a 64-bit double-precision bit pattern into the 32-bit single-precision pattern that a floating-point register store would write to memory. It is a pure bit-selection datapath, not an arithmetic conversion. It never rounds and has no exception or status outputs. Signalling NaNs keep their quiet bit unchanged, and fraction bits that do not fit are simply dropped.

The input's biased exponent decides which of three paths applies. Above the single-precision normal threshold, the sign, the exponent MSB, the low exponent bits and the top fraction bits are copied through. Inside a fixed window just below that threshold, the block makes a single-precision denormal by shifting the significand, with its hidden one restored, right by an amount set by the exponent. Below the window the result is a zero that keeps the input's sign. The output can be registered (one cycle of latency, cleared by reset) or combinational. A parameter selects which.

Top module: `dbl_store_narrow`

## Requirements
- R1: Output bit 31 always equals input bit 63 (the sign), on every path.
- R2: When the input exponent e = in[62:52] is greater than 896, the output is {in[63:62], in[58:29]}. So out[30] = in[62], out[29:23] = in[58:52] and out[22:0] = in[51:29]. For example, 0x3FF0000000000000 gives 0x3F800000.
- R3: An input with e = 2047 (infinity or NaN) gives output exponent field out[30:23] = 0xFF. The output fraction is in[51:29] with no quieting, so a signalling NaN stays signalling.
- R4: When 874 <= e <= 896, out[30:23] = 0. out[22:0] takes the low 23 bits of ({1, in[51:0]} >> (926 - e)), and that value is never zero. For example, 0x36A0000000000000 gives 0x00000001.
- R5: When e < 874 (this includes zeros and double denormals), the output is the input sign in bit 31 followed by 31 zero bits. For example, 0x0000000000000001 gives 0x00000000.
- R6: The path boundaries are exact. e = 896 takes the denormal path and e = 897 takes the normal path, which gives output exponent field 1. e = 873 flushes to zero.
- R7: Take any 32-bit single pattern, widen it exactly to double (denormals normalised, infinity and NaN mapped to e = 2047 with the fraction shifted up by 29), and pass it through the block. The result equals the original 32 bits.
- R8: With the output register enabled (the default), the output shows the converted value one clock after the input is applied and holds until the next edge. While reset is low the output is 0x00000000.
- R9: No rounding. When e > 896, input bits 28:0 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| dbl_in | input | 64 | Double-precision bit pattern to narrow |
| sgl_out | output | 32 | Single-precision bit pattern |

## Verification
The bench targets the edges of the exponent window: 873, 874, 896 and 897. A design with an off-by-one threshold would flush a valid denormal to zero, or would send an exponent-896 input down the normal path and give a wrong exponent field. Signalling NaNs and inputs whose low 29 bits are all ones expose any quieting or rounding. A rounding design would bump the fraction or carry into the exponent. A round trip over random single patterns catches a misplaced bit in the normal-path selection, such as dropping the exponent bit that turns 1.0 into 0x1F800000. Negative inputs on the flush path catch a sign that is lost instead of kept.

// File: rtl/dsn_pkg.sv
package dsn_pkg;
   typedef enum logic [1:0] {
      CLS_NORMAL = 2'd0,
      CLS_DENORM = 2'd1,
      CLS_FLUSH  = 2'd2
   } narrow_cls_e;
endpackage

// File: rtl/dsn_classify.sv
module dsn_classify
   import dsn_pkg::*;
#(
   parameter int DBL_EXP_W  = 11,
   parameter int NORM_LIMIT = 896,
   parameter int DEN_LOW    = 874
) (
   input  logic [DBL_EXP_W-1:0] exp_i,
   output narrow_cls_e          cls_o
);
   localparam logic [DBL_EXP_W-1:0] LIM_V = DBL_EXP_W'(NORM_LIMIT);
   localparam logic [DBL_EXP_W-1:0] LOW_V = DBL_EXP_W'(DEN_LOW);

   always_comb begin
      if (exp_i > LIM_V)       cls_o = CLS_NORMAL;
      else if (exp_i >= LOW_V) cls_o = CLS_DENORM;
      else                     cls_o = CLS_FLUSH;
   end
endmodule

// File: rtl/dsn_norm_path.sv
module dsn_norm_path #(
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   localparam int BODY_W    = SGL_EXP_W + SGL_FRAC_W
) (
   input  logic                  exp_msb_i,
   input  logic [SGL_EXP_W-2:0]  exp_low_i,
   input  logic [SGL_FRAC_W-1:0] frac_top_i,
   output logic [BODY_W-1:0]     body_o
);
   // Exponent rebias by bit selection: the MSB survives, the middle bits drop.
   assign body_o = {exp_msb_i, exp_low_i, frac_top_i};
endmodule

// File: rtl/dsn_denorm_path.sv
module dsn_denorm_path #(
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_FRAC_W = 52,
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   parameter int SHIFT_BASE = 926,
   localparam int BODY_W    = SGL_EXP_W + SGL_FRAC_W
) (
   input  logic [DBL_EXP_W-1:0]  exp_i,
   input  logic [DBL_FRAC_W-1:0] frac_i,
   output logic [BODY_W-1:0]     body_o
);
   logic [DBL_FRAC_W:0]  mant;
   logic [DBL_EXP_W-1:0] shamt;
   logic [SGL_FRAC_W-1:0] frac_out;

   assign mant     = {1'b1, frac_i};
   assign shamt    = DBL_EXP_W'(SHIFT_BASE) - exp_i;
   assign frac_out = SGL_FRAC_W'(mant >> shamt);
   assign body_o   = {{SGL_EXP_W{1'b0}}, frac_out};
endmodule

// File: rtl/dbl_store_narrow.sv
module dbl_store_narrow
   import dsn_pkg::*;
#(
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_FRAC_W = 52,
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   parameter bit OUT_REG    = 1'b1,
   localparam int DBL_W     = 1 + DBL_EXP_W + DBL_FRAC_W,
   localparam int SGL_W     = 1 + SGL_EXP_W + SGL_FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DBL_W-1:0] dbl_in,
   output logic [SGL_W-1:0] sgl_out
);
   localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
   localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
   localparam int NORM_LIMIT = DBL_BIAS - SGL_BIAS;
   localparam int DEN_LOW    = NORM_LIMIT - SGL_FRAC_W + 1;
   localparam int SHIFT_BASE = NORM_LIMIT + DBL_FRAC_W - SGL_FRAC_W + 1;
   localparam int BODY_W     = SGL_W - 1;

   if (SGL_EXP_W < 2 || SGL_EXP_W >= DBL_EXP_W) begin : g_bad_exp
      $error("dbl_store_narrow: single exponent width must be 2..DBL_EXP_W-1");
   end
   if (SGL_FRAC_W < 1 || SGL_FRAC_W >= DBL_FRAC_W) begin : g_bad_frac
      $error("dbl_store_narrow: single fraction must be narrower than double");
   end
   if (SHIFT_BASE >= (1 << DBL_EXP_W)) begin : g_bad_shift
      $error("dbl_store_narrow: shift base does not fit the exponent width");
   end

   logic                  sign;
   logic [DBL_EXP_W-1:0]  exp_f;
   logic [DBL_FRAC_W-1:0] frac_f;
   narrow_cls_e           cls;
   logic [BODY_W-1:0]     body_norm, body_den, body_sel;
   logic [SGL_W-1:0]      result;

   assign sign   = dbl_in[DBL_W-1];
   assign exp_f  = dbl_in[DBL_W-2 -: DBL_EXP_W];
   assign frac_f = dbl_in[DBL_FRAC_W-1:0];

   dsn_classify #(
      .DBL_EXP_W (DBL_EXP_W),
      .NORM_LIMIT(NORM_LIMIT),
      .DEN_LOW   (DEN_LOW)
   ) u_classify (
      .exp_i(exp_f),
      .cls_o(cls)
   );

   dsn_norm_path #(
      .SGL_EXP_W (SGL_EXP_W),
      .SGL_FRAC_W(SGL_FRAC_W)
   ) u_norm (
      .exp_msb_i (exp_f[DBL_EXP_W-1]),
      .exp_low_i (exp_f[SGL_EXP_W-2:0]),
      .frac_top_i(frac_f[DBL_FRAC_W-1 -: SGL_FRAC_W]),
      .body_o    (body_norm)
   );

   dsn_denorm_path #(
      .DBL_EXP_W (DBL_EXP_W),
      .DBL_FRAC_W(DBL_FRAC_W),
      .SGL_EXP_W (SGL_EXP_W),
      .SGL_FRAC_W(SGL_FRAC_W),
      .SHIFT_BASE(SHIFT_BASE)
   ) u_denorm (
      .exp_i (exp_f),
      .frac_i(frac_f),
      .body_o(body_den)
   );

   always_comb begin
      unique case (cls)
         CLS_NORMAL: body_sel = body_norm;
         CLS_DENORM: body_sel = body_den;
         default:    body_sel = '0;
      endcase
   end

   assign result = {sign, body_sel};

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) sgl_out <= '0;
         else        sgl_out <= result;
      end
   end else begin : g_comb
      assign sgl_out = result;
   end
endmodule

// File: rtl/dbl_store_narrow_chk.sv
module dbl_store_narrow_chk #(
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_FRAC_W = 52,
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   parameter bit OUT_REG    = 1'b1,
   localparam int DBL_W     = 1 + DBL_EXP_W + DBL_FRAC_W,
   localparam int SGL_W     = 1 + SGL_EXP_W + SGL_FRAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DBL_W-1:0] dbl_in,
   input logic [SGL_W-1:0] sgl_out
);
   localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
   localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
   localparam int NORM_LIMIT = DBL_BIAS - SGL_BIAS;
   localparam int DEN_LOW    = NORM_LIMIT - SGL_FRAC_W + 1;
   localparam int CUT        = DBL_FRAC_W - SGL_FRAC_W;

   // Input aligned with the output it produced.
   logic [DBL_W-1:0] in_q;
   if (OUT_REG) begin : g_align_reg
      always_ff @(posedge clk) begin
         if (!rst_n) in_q <= '0;
         else        in_q <= dbl_in;
      end
   end else begin : g_align_comb
      assign in_q = dbl_in;
   end

   logic [DBL_EXP_W-1:0] e_q;
   logic [SGL_EXP_W-1:0] oexp;
   assign e_q  = in_q[DBL_W-2 -: DBL_EXP_W];
   assign oexp = sgl_out[SGL_W-2 -: SGL_EXP_W];

   assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sgl_out[SGL_W-1] == in_q[DBL_W-1]);

   assert_normal_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (e_q > DBL_EXP_W'(NORM_LIMIT)) |->
         (sgl_out[SGL_W-2] == in_q[DBL_W-2]) &&
         (sgl_out[SGL_FRAC_W-1:0] == in_q[DBL_FRAC_W-1 -: SGL_FRAC_W]));

   assert_special_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&e_q) |-> (&oexp));

   assert_denorm_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (e_q <= DBL_EXP_W'(NORM_LIMIT) && e_q >= DBL_EXP_W'(DEN_LOW)) |->
         (oexp == '0) && (sgl_out[SGL_FRAC_W-1:0] != '0));

   assert_flush_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (e_q < DBL_EXP_W'(DEN_LOW)) |-> (sgl_out[SGL_W-2:0] == '0));

   assert_no_rounding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_q >> CUT) == ($past(in_q) >> CUT)) && (e_q > DBL_EXP_W'(NORM_LIMIT))
         |-> $stable(sgl_out));
endmodule

bind dbl_store_narrow dbl_store_narrow_chk #(
   .DBL_EXP_W (DBL_EXP_W),
   .DBL_FRAC_W(DBL_FRAC_W),
   .SGL_EXP_W (SGL_EXP_W),
   .SGL_FRAC_W(SGL_FRAC_W),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .dbl_in (dbl_in),
   .sgl_out(sgl_out)
);

// File: tb/dbl_store_narrow_bench.sv
`timescale 1ns/1ps
module dbl_store_narrow_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] dbl_in = '0;
   logic [31:0] sgl_out;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   dbl_store_narrow u_dbl_store_narrow (
      .clk    (clk),
      .rst_n  (rst_n),
      .dbl_in (dbl_in),
      .sgl_out(sgl_out)
   );

   function automatic logic [31:0] narrow_ref(logic [63:0] d);
      int          e;
      logic [52:0] m;
      e = int'(d[62:52]);
      if (e > 896) return {d[63:62], d[58:29]};
      if (e >= 874) begin
         m = {1'b1, d[51:0]} >> (926 - e);
         return {d[63], 8'd0, m[22:0]};
      end
      return {d[63], 31'd0};
   endfunction

   function automatic logic [63:0] widen(logic [31:0] s);
      logic [7:0]  se;
      logic [22:0] sf;
      logic [51:0] df;
      int          k;
      se = s[30:23];
      sf = s[22:0];
      if (se == 8'hFF) return {s[31], 11'h7FF, sf, 29'd0};
      if (se != 0)     return {s[31], 11'(int'(se) + 896), sf, 29'd0};
      if (sf == 0)     return {s[31], 63'd0};
      k = 0;
      for (int i = 0; i < 23; i++) if (sf[i]) k = i;
      df = 52'(sf) << (52 - k);
      return {s[31], 11'(k + 874), df};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [63:0] d);
      @(negedge clk);
      dbl_in = d;
      @(negedge clk);
   endtask

   task automatic dir(string tag, logic [63:0] d, logic [31:0] exp);
      apply(d);
      check(tag, sgl_out, exp);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R8: reset clears the registered output
      dbl_in = 64'h3FF0000000000000;
      repeat (3) @(negedge clk);
      check("R8 reset value", sgl_out, 32'h0);
      rst_n = 1'b1;

      dir("R2 one",        64'h3FF0000000000000, 32'h3F800000);
      dir("R2 negative",   64'hBFCC361140000000, 32'hBE61B08A);
      dir("R2 fraction",   64'h3FE19999A0000000, 32'h3F0CCCCD);
      dir("R4 smallest",   64'h36A0000000000000, 32'h00000001);
      dir("R5 tiny",       64'h0000000000000001, 32'h00000000);
      dir("R5 neg flush",  64'h8000000000000007, 32'h80000000);
      dir("R5 neg zero",   64'h8000000000000000, 32'h80000000);
      dir("R6 e896",       64'h3800000000000000, 32'h00400000);
      dir("R6 e897",       64'h3810000000000000, 32'h00800000);
      dir("R6 e873",       64'h369FFFFFFFFFFFFF, 32'h00000000);
      dir("R4 e874 full",  64'hB6AFFFFFFFFFFFFF, 32'h80000001);
      dir("R3 inf",        64'hFFF0000000000000, 32'hFF800000);
      dir("R3 snan",       64'h7FF0000020000000, 32'h7F800001);
      dir("R3 qnan",       64'h7FF8000000000000, 32'h7FC00000);
      dir("R9 low ones",   64'h3FF000001FFFFFFF, 32'h3F800000);
      dir("R9 max finite", 64'h47EFFFFFFFFFFFFF, 32'h7F7FFFFF);
      dir("R1 sign",       64'hC000000000000000, 32'hC0000000);

      // R8: output holds until the next clock edge
      @(negedge clk);
      dbl_in = 64'h4000000000000000;
      #1;
      check("R8 hold before edge", sgl_out, 32'hC0000000);
      @(negedge clk);
      check("R8 one cycle latency", sgl_out, 32'h40000000);

      // R2 R4 R5: random doubles focused on the window
      for (int n = 0; n < 2000; n++) begin
         logic [63:0] d;
         d = {$urandom(), $urandom()};
         if (n % 2 == 0) d[62:52] = 11'($urandom_range(865, 905));
         apply(d);
         check("R2/R4/R5 random double", sgl_out, narrow_ref(d));
      end

      // R7: single -> double -> single round trip
      for (int n = 0; n < 2000; n++) begin
         logic [31:0] s;
         s = $urandom();
         if (n % 4 == 1) s[30:23] = 8'h00;
         if (n % 4 == 2) s[30:23] = 8'hFF;
         apply(widen(s));
         check("R7 round trip", sgl_out, s);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule